// File: doc/BRIEF.md
# Single-Operand ALU with Condition Flags

This unit performs the one-operand arithmetic, logical, shift and rotate operations of a 16-bit minicomputer-style instruction set. An operation code, a byte/word select, a 16-bit operand and the current N, Z, V and C flags are presented at the inputs. The result is available combinationally in the same cycle. The new flags are captured into a flag register on the clock edge where the execute strobe is high.

A single masked datapath serves both widths. In byte mode only the low eight bits take part in the operation. The upper byte of the operand reaches the result untouched, and N and Z are judged on the low byte. Byte swap and sign-extend always work on the full word, whatever the byte select says. The surrounding sequencer is responsible for addressing, operand fetch and write-back.

Top module: `sop_alu`

## Requirements
- R1: While reset is low and after its release, before any execute strobe, the flag register reads 0. Flags pack as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: The flag register loads the new flags on a rising clock edge where exec is high, and holds its value when exec is low. The result output is combinational and follows the inputs in the same cycle.
- R3: Code 0 (clear) gives a zero result with flags N=0, Z=1, V=0, C=0. Code 1 (complement) gives the bitwise inverse with V=0 and C=1.
- R4: Code 2 (increment) adds one and sets V only when the operand was the largest positive value (0x7F byte, 0x7FFF word). Code 3 (decrement) subtracts one and sets V only when the operand was the most negative value (0x80 or 0x8000). Both pass C through unchanged.
- R5: Code 4 (negate) gives the two's complement. V=1 exactly when the result is 0x80 (byte) or 0x8000 (word), and C=1 unless the result is zero.
- R6: Code 5 (test) returns the operand unchanged, takes N and Z from it, and clears V and C.
- R7: Code 6 (arithmetic right shift) keeps the old MSB in the MSB and moves the old LSB into C. Code 7 (arithmetic left shift) shifts a zero into the LSB and moves the old MSB into C.
- R8: Code 8 (rotate right) moves the incoming C into the MSB and the old LSB into C. Code 9 (rotate left) moves the incoming C into the LSB and the old MSB into C.
- R9: For codes 6 to 9 the new V equals the XOR of the new N and the new C.
- R10: Code 10 (byte swap) exchanges the two bytes of the full word in either mode. N comes from result bit 15, Z tests all 16 bits, and V and C are cleared.
- R11: Code 11 (add carry) adds the incoming C: the new C is the carry out of the selected width, and V marks signed overflow. Code 12 (subtract carry) subtracts the incoming C: the new C marks a borrow, and V marks signed overflow.
- R12: Code 13 (sign-extend) outputs 0xFFFF when the incoming N is 1 and 0x0000 otherwise, always as a full word. Z is set to the inverse of N, and N, V and C keep their incoming values.
- R13: With byte_sel=1, codes 0 to 9, 11 and 12 act on bits 7:0 only. Bits 15:8 of the result equal those of the operand, N is taken from bit 7, and Z tests bits 7:0 only.
- R14: Codes 14 and 15 are inert: the result equals the operand and the new flags equal flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| exec | input | 1 | Load strobe for the flag register |
| op | input | 4 | Operation code |
| byte_sel | input | 1 | 1 = byte operation, 0 = word operation |
| opnd | input | 16 | Operand |
| flags_in | input | 4 | Incoming N,Z,V,C |
| result | output | 16 | Combinational result |
| flags_q | output | 4 | Registered N,Z,V,C |

## Verification
The sweep targets the width-dependent edges: 0x7F/0x7FFF on increment, 0x80/0x8000 on decrement and negate, and all-ones under add-carry and zero under subtract-carry. A datapath that used the wrong width there would set V or C on the wrong value, or let a carry spill into the upper byte. Every byte value is run with varied upper bytes, so a byte path that leaked into bits 15:8, or took N from bit 15, is exposed. Shifts and rotates are driven with both carry states, which catches a rotate that drops the incoming C or a V that is not N XOR C. Sign-extend and byte swap are also run with byte_sel high, and a design that honoured it for them would clip the result. A final step drops exec and shows the flags holding.

// File: rtl/sop_alu.sv
module sop_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec,
  input  logic [3:0]  op,
  input  logic        byte_sel,
  input  logic [15:0] opnd,
  input  logic [3:0]  flags_in,
  output logic [15:0] result,
  output logic [3:0]  flags_q
);
  localparam logic [3:0] OP_CLR = 4'd0,  OP_COM = 4'd1,  OP_INC = 4'd2,  OP_DEC = 4'd3;
  localparam logic [3:0] OP_NEG = 4'd4,  OP_TST = 4'd5,  OP_ASR = 4'd6,  OP_ASL = 4'd7;
  localparam logic [3:0] OP_ROR = 4'd8,  OP_ROL = 4'd9,  OP_SWP = 4'd10, OP_ADC = 4'd11;
  localparam logic [3:0] OP_SBC = 4'd12, OP_SXT = 4'd13;

  logic        wide, cin, nin, msb_in, shift_op, pass;
  logic [15:0] mask, sgn, xm, rl;
  logic        v_n, c_n, n_n, z_n;
  logic [3:0]  flags_nxt;

  assign wide     = !byte_sel || op == OP_SWP || op == OP_SXT;
  assign mask     = wide ? 16'hFFFF : 16'h00FF;
  assign sgn      = wide ? 16'h8000 : 16'h0080;
  assign xm       = opnd & mask;
  assign msb_in   = |(xm & sgn);
  assign cin      = flags_in[0];
  assign nin      = flags_in[3];
  assign shift_op = op == OP_ASR || op == OP_ASL || op == OP_ROR || op == OP_ROL;
  assign pass     = op > OP_SXT;

  always_comb begin
    rl  = xm;
    v_n = 1'b0;
    c_n = cin;
    case (op)
      OP_CLR: begin rl = 16'h0000; c_n = 1'b0; end
      OP_COM: begin rl = ~xm & mask; c_n = 1'b1; end
      OP_INC: begin rl = (xm + 16'd1) & mask; v_n = xm == (sgn - 16'd1); end
      OP_DEC: begin rl = (xm - 16'd1) & mask; v_n = xm == sgn; end
      OP_NEG: begin
        rl  = (~xm + 16'd1) & mask;
        v_n = rl == sgn;
        c_n = rl != 16'h0000;
      end
      OP_TST: c_n = 1'b0;
      OP_ASR: begin rl = (xm >> 1) | (msb_in ? sgn : 16'h0000); c_n = xm[0]; end
      OP_ASL: begin rl = (xm << 1) & mask; c_n = msb_in; end
      OP_ROR: begin rl = (xm >> 1) | (cin ? sgn : 16'h0000); c_n = xm[0]; end
      OP_ROL: begin rl = ((xm << 1) & mask) | {15'd0, cin}; c_n = msb_in; end
      OP_SWP: begin rl = {opnd[7:0], opnd[15:8]}; c_n = 1'b0; end
      OP_ADC: begin
        rl  = (xm + {15'd0, cin}) & mask;
        c_n = cin && xm == mask;
        v_n = cin && xm == (sgn - 16'd1);
      end
      OP_SBC: begin
        rl  = (xm - {15'd0, cin}) & mask;
        c_n = cin && xm == 16'h0000;
        v_n = cin && xm == sgn;
      end
      OP_SXT: rl = {16{nin}};
      default: rl = xm;
    endcase
  end

  assign result = pass ? opnd : ((opnd & ~mask) | rl);
  assign n_n    = wide ? result[15] : result[7];
  assign z_n    = (result & mask) == 16'h0000;

  always_comb begin
    if (pass)              flags_nxt = flags_in;
    else if (op == OP_SXT) flags_nxt = {nin, !nin, flags_in[1], cin};
    else                   flags_nxt = {n_n, z_n, shift_op ? (n_n ^ c_n) : v_n, c_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= 4'h0;
    else if (exec) flags_q <= flags_nxt;
  end

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(flags_q));

  // R3
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_CLR |=> flags_q == 4'b0100);

  // R4
  inc_dec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == OP_INC || op == OP_DEC) |=> flags_q[0] == $past(flags_in[0]));

  // R9
  shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && shift_op |=> flags_q[1] == (flags_q[3] ^ flags_q[0]));

  // R13
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sel && op <= OP_SBC && op != OP_SWP |-> result[15:8] == opnd[15:8]);

  // R14
  inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op > OP_SXT |=> flags_q == $past(flags_in));
endmodule

// File: tb/sim_sop_alu.sv
module sim_sop_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        byte_sel = 1'b0;
  logic [15:0] opnd = 16'h0000;
  logic [3:0]  flags_in = 4'h0;
  logic [15:0] result;
  logic [3:0]  flags_q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sop_alu u0 (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .byte_sel(byte_sel),
              .opnd(opnd), .flags_in(flags_in), .result(result), .flags_q(flags_q));

  function automatic logic [19:0] model(input int o, input bit b, input logic [15:0] a,
                                        input logic [3:0] f);
    int w, m, h, v, r;
    bit n, z, vv, c, ci;
    if (o >= 14) return {a, f};
    w  = (b && o != 10 && o != 13) ? 8 : 16;
    m  = (1 << w) - 1;
    h  = 1 << (w - 1);
    v  = int'(a) & m;
    ci = f[0];
    vv = 0; c = ci; r = v;
    case (o)
      0:  begin r = 0; c = 0; end
      1:  begin r = m - v; c = 1; end
      2:  begin r = (v + 1) % (m + 1); vv = (v == h - 1); end
      3:  begin r = (v + m) % (m + 1); vv = (v == h); end
      4:  begin r = (m + 1 - v) % (m + 1); vv = (r == h); c = (r != 0); end
      5:  begin r = v; c = 0; end
      6:  begin r = v / 2 + ((v >= h) ? h : 0); c = v[0]; end
      7:  begin r = (v * 2) % (m + 1); c = (v >= h); end
      8:  begin r = v / 2 + (ci ? h : 0); c = v[0]; end
      9:  begin r = (v * 2) % (m + 1) + int'(ci); c = (v >= h); end
      10: begin r = ((int'(a) & 255) * 256) + (int'(a) / 256); c = 0; end
      11: begin r = (v + int'(ci)) % (m + 1); c = (v + int'(ci)) > m; vv = ci && v == h - 1; end
      12: begin r = (v - int'(ci) + m + 1) % (m + 1); c = v < int'(ci); vv = ci && v == h; end
      default: r = f[3] ? 65535 : 0;
    endcase
    n = r >= h;
    z = r == 0;
    if (o >= 6 && o <= 9) vv = n ^ c;
    if (o == 13) return {16'(r), f[3], !f[3], f[1], f[0]};
    if (w == 8) r = (int'(a) & 16'hFF00) | r;
    return {16'(r), n, z, vv, c};
  endfunction

  function automatic string tag(input int o, input bit b);
    string s;
    case (o)
      0, 1:   s = "R3";
      2, 3:   s = "R4";
      4:      s = "R5";
      5:      s = "R6";
      6, 7:   s = "R7 R9";
      8, 9:   s = "R8 R9";
      10:     s = "R10";
      11, 12: s = "R11";
      13:     s = "R12";
      default: s = "R14";
    endcase
    if (b && o < 13 && o != 10) s = {s, " R13"};
    return s;
  endfunction

  task automatic run(input int o, input bit b, input logic [15:0] a, input logic [3:0] f);
    logic [19:0] e;
    e = model(o, b, a, f);
    @(negedge clk);
    op = 4'(o); byte_sel = b; opnd = a; flags_in = f; exec = 1'b1;
    #1;
    n_chk++;
    if (result !== e[19:4]) begin
      n_bad++;
      $display("FAIL %s result op=%0d byte=%0b a=%h f=%b: got %h exp %h", tag(o, b), o, b, a, f, result, e[19:4]);
    end
    @(posedge clk);
    #1;
    n_chk++;
    if (flags_q !== e[3:0]) begin
      n_bad++;
      $display("FAIL %s flags op=%0d byte=%0b a=%h f=%b: got %b exp %b", tag(o, b), o, b, a, f, flags_q, e[3:0]);
    end
  endtask

  logic [15:0] corners [12] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE,
                                16'h8001, 16'h7FFE, 16'h00FF, 16'h0100, 16'hA5C3, 16'h0080};
  logic [3:0]  fpat [4] = '{4'b0000, 4'b0001, 4'b1010, 4'b1111};

  initial begin
    logic [15:0] lcg;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (flags_q !== 4'h0) begin
      n_bad++;
      $display("FAIL R1 flags in reset: got %b exp 0000", flags_q);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    n_chk++;
    if (flags_q !== 4'h0) begin
      n_bad++;
      $display("FAIL R1 flags after reset: got %b exp 0000", flags_q);
    end
    // byte sweep: every low byte, varied upper byte (R13)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 256; i++)
        for (int k = 0; k < 4; k++)
          run(o, 1'b1, {8'((i * 37 + k * 91) & 255), 8'(i)}, fpat[k]);
    // word sweep: corners then pseudo-random operands
    lcg = 16'h1D2B;
    for (int o = 0; o < 16; o++) begin
      for (int j = 0; j < 12; j++)
        for (int k = 0; k < 4; k++)
          run(o, 1'b0, corners[j], fpat[k]);
      for (int j = 0; j < 300; j++) begin
        lcg = lcg * 16'd25173 + 16'd13849;
        for (int k = 0; k < 4; k++)
          run(o, 1'b0, lcg, fpat[k]);
      end
    end
    // R2: flags hold when exec is low, result still follows inputs
    run(0, 1'b0, 16'h1234, 4'b1011);
    @(negedge clk);
    exec = 1'b0; op = 4'd1; byte_sel = 1'b0; opnd = 16'h00F0; flags_in = 4'b1001;
    #1;
    n_chk++;
    if (result !== 16'hFF0F) begin
      n_bad++;
      $display("FAIL R2 combinational result: got %h exp ff0f", result);
    end
    @(posedge clk); #1;
    n_chk++;
    if (flags_q !== 4'b0100) begin
      n_bad++;
      $display("FAIL R2 hold without exec: got %b exp 0100", flags_q);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule